// File: doc/BRIEF.md
# Signed-Magnitude Restoring Divider

This block divides a double-length unsigned magnitude by a single-length magnitude. Each operand has its own sign bit. The dividend is 2N bits wide: its high half goes into a working register A and its low half into Q. The divisor sits in B, and a carry flip-flop E extends A by one bit.

After it accepts the operands, the block makes one trial subtraction of B from the high half. If that half is not smaller than the divisor, the quotient would not fit in N bits, so the block raises the overflow flag and reports at once. Otherwise it adds B back and runs N steps under a step counter. In each step it shifts E:A:Q left by one place and subtracts B. If the result is negative it adds B back.

At the end, Q holds the quotient magnitude and A holds the remainder. The quotient sign is the exclusive-OR of the two operand signs, and the remainder carries the dividend's sign.

Operands enter through a valid/ready handshake. The input side is ready only while the block is idle, so any offer made while a division runs is neither taken nor stored. The result leaves through a second valid/ready pair and is held steady until the consumer takes it. A consumer that keeps ready low stalls the block in its finished state with every result output unchanged.

Top module: `restoring_sm_divider`

## Requirements
- R1: `in_ready` is 1 only while idle. Operands are captured on a clock edge where `in_valid` and `in_ready` are both 1, and `in_ready` is 0 in the following cycle.
- R2: If the dividend's upper N bits are greater than or equal to the divisor (this includes a zero divisor), `out_overflow` is 1 with the result.
- R3: Without overflow, quotient × divisor + remainder equals the dividend magnitude and the remainder is less than the divisor.
- R4: `out_quotient_sign` equals `in_dividend_sign` XOR `in_divisor_sign` of the accepted operands.
- R5: `out_remainder_sign` equals the accepted `in_dividend_sign`.
- R6: On overflow, `out_valid` rises exactly 2 clock edges after the accepting edge.
- R7: Without overflow, `out_valid` rises exactly 2N+3+Z edges after the accepting edge. Z is the number of zero bits in the N-bit quotient, because every zero quotient bit costs one restore cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and all result outputs hold their values. A transfer with `out_ready` = 1 returns the block to idle.
- R9: `in_valid` asserted while busy has no effect: the running result is unchanged and no second result appears.
- R10: The result is correct when a shift carries a 1 into E, which happens when the partial remainder exceeds N bits (divisor with its top bit set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands offered |
| in_ready | output | 1 | Block idle, will accept operands |
| in_dividend | input | 2N | Dividend magnitude |
| in_dividend_sign | input | 1 | Dividend sign (1 = negative) |
| in_divisor | input | N | Divisor magnitude |
| in_divisor_sign | input | 1 | Divisor sign (1 = negative) |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_quotient | output | N | Quotient magnitude |
| out_quotient_sign | output | 1 | Quotient sign |
| out_remainder | output | N | Remainder magnitude |
| out_remainder_sign | output | 1 | Remainder sign |
| out_overflow | output | 1 | Divide overflow; quotient and remainder not meaningful |

## Verification
The bench targets four corner cases:

- **Overflow boundary.** The high half equals the divisor, and the divisor is zero. A comparison that is off by one would run the loop and return a truncated quotient with no flag.
- **Carry into E.** The divisor is 0xFF. A design that ignores E after the shift would skip the subtraction and corrupt both the quotient and the remainder.
- **Latency.** Latency is checked against the count of zero quotient bits. A missed restore, or an extra or missing step, would shift `out_valid`.
- **Back-pressure and busy offers.** The bench stalls the output and offers new operands mid-run. A leaky handshake would change held outputs or start a second division.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OVCHK,
    ST_ADDBK,
    ST_SHIFT,
    ST_TRIAL,
    ST_RESTORE,
    ST_FINISH
  } rsd_state_e;
endpackage

// File: rtl/div_addsub.sv
module div_addsub #(
  parameter int N = 8
) (
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  input  logic         sub,
  output logic [N-1:0] sum,
  output logic         carry
);
  logic [N:0] total;

  always_comb begin
    total = {1'b0, opa} + {1'b0, opb ^ {N{sub}}} + {{N{1'b0}}, sub};
    sum   = total[N-1:0];
    carry = total[N];
  end
endmodule

// File: rtl/div_seq_ctrl.sv
module div_seq_ctrl
  import rsd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       out_ready,
  input  logic       e_bit,
  input  logic       carry,
  output rsd_state_e state
);
  localparam int SCW = $clog2(N + 1);

  logic [SCW-1:0] sc;
  rsd_state_e     nxt;
  logic           last_step;

  assign last_step = (sc == SCW'(1));

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:    if (start) nxt = ST_OVCHK;
      ST_OVCHK:   nxt = carry ? ST_FINISH : ST_ADDBK;
      ST_ADDBK:   nxt = ST_SHIFT;
      ST_SHIFT:   nxt = ST_TRIAL;
      ST_TRIAL:   if (e_bit || carry) nxt = last_step ? ST_FINISH : ST_SHIFT;
                  else                nxt = ST_RESTORE;
      ST_RESTORE: nxt = last_step ? ST_FINISH : ST_SHIFT;
      ST_FINISH:  if (out_ready) nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sc    <= '0;
    end else begin
      state <= nxt;
      if (state == ST_ADDBK) begin
        sc <= SCW'(N);
      end else if ((state == ST_TRIAL && (e_bit || carry)) || state == ST_RESTORE) begin
        sc <= sc - SCW'(1);
      end
    end
  end

  // R7: the step counter never leaves 0..N
  a_r7_sc_range: assert property (@(posedge clk) disable iff (!rst_n)
    sc <= SCW'(N));

  // R7: the loop ends only on the last step
  a_r7_finish_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {ST_TRIAL, ST_RESTORE}) && nxt == ST_FINISH |-> last_step);
endmodule

// File: rtl/restoring_sm_divider.sv
module restoring_sm_divider
  import rsd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [2*N-1:0] in_dividend,
  input  logic           in_dividend_sign,
  input  logic [N-1:0]   in_divisor,
  input  logic           in_divisor_sign,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [N-1:0]   out_quotient,
  output logic           out_quotient_sign,
  output logic [N-1:0]   out_remainder,
  output logic           out_remainder_sign,
  output logic           out_overflow
);
  rsd_state_e   state;
  logic [N-1:0] a_q, q_q, b_q;
  logic         e_q, as_q, bs_q, dvf_q;
  logic [N-1:0] sum;
  logic         carry, sub;

  assign sub = (state == ST_OVCHK) || (state == ST_TRIAL);

  div_addsub #(.N(N)) u_alu (
    .opa(a_q), .opb(b_q), .sub(sub), .sum(sum), .carry(carry)
  );

  div_seq_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(in_valid), .out_ready(out_ready),
    .e_bit(e_q), .carry(carry), .state(state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0; q_q <= '0; b_q <= '0;
      e_q <= 1'b0; as_q <= 1'b0; bs_q <= 1'b0; dvf_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (in_valid) begin
          a_q   <= in_dividend[2*N-1:N];
          q_q   <= in_dividend[N-1:0];
          b_q   <= in_divisor;
          as_q  <= in_dividend_sign;
          bs_q  <= in_divisor_sign;
          e_q   <= 1'b0;
          dvf_q <= 1'b0;
        end
        ST_OVCHK: begin
          a_q   <= sum;
          e_q   <= carry;
          dvf_q <= carry;
        end
        ST_ADDBK, ST_RESTORE: begin
          a_q <= sum;
          e_q <= 1'b0;
        end
        ST_SHIFT: {e_q, a_q, q_q} <= {a_q, q_q, 1'b0};
        ST_TRIAL: begin
          a_q <= sum;
          e_q <= e_q ? 1'b0 : carry;
          if (e_q || carry) q_q[0] <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign in_ready           = (state == ST_IDLE);
  assign out_valid          = (state == ST_FINISH);
  assign out_quotient       = q_q;
  assign out_remainder      = a_q;
  assign out_quotient_sign  = as_q ^ bs_q;
  assign out_remainder_sign = as_q;
  assign out_overflow       = dvf_q;

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  a_r2_zero_divisor_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && b_q == '0 |-> out_overflow);

  a_r3_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_overflow |-> out_remainder < b_q);

  a_r6_ovf_fast: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_dividend[2*N-1:N] >= in_divisor |-> ##2 out_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_quotient) &&
      $stable(out_remainder) && $stable(out_overflow) &&
      $stable(out_quotient_sign) && $stable(out_remainder_sign));

  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(b_q) || $past(state) == ST_FINISH);
endmodule

// File: tb/sim_restoring_sm_divider.sv
`timescale 1ns/1ps
module sim_restoring_sm_divider;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [2*N-1:0] in_dividend = '0;
  logic in_dividend_sign = 1'b0, in_divisor_sign = 1'b0;
  logic [N-1:0] in_divisor = '0;
  logic in_ready, out_valid, out_quotient_sign, out_remainder_sign, out_overflow;
  logic [N-1:0] out_quotient, out_remainder;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  restoring_sm_divider #(.N(N)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int zero_bits(input logic [N-1:0] v);
    int z = 0;
    for (int i = 0; i < N; i++) if (!v[i]) z++;
    return z;
  endfunction

  // Offer operands, wait for acceptance edge, optionally disturb, count latency, check.
  task automatic run_div(input logic [2*N-1:0] dvd, input logic ds,
                         input logic [N-1:0] dvs, input logic bs,
                         input int stall, input bit poke_busy);
    int cyc;
    bit ovf_exp;
    logic [N-1:0] q_exp, r_exp;
    ovf_exp = (dvd[2*N-1:N] >= dvs);
    q_exp = '0; r_exp = '0;
    if (!ovf_exp) begin
      q_exp = N'(dvd / dvs);
      r_exp = N'(dvd % dvs);
    end
    @(negedge clk);
    in_dividend = dvd; in_dividend_sign = ds; in_divisor = dvs; in_divisor_sign = bs;
    in_valid = 1'b1;
    out_ready = (stall == 0);
    @(posedge clk);
    @(negedge clk);
    chk(!in_ready, "R1 busy after accept", in_ready, 0);
    if (poke_busy) begin
      in_dividend = 16'h0302; in_divisor = 8'h05; in_dividend_sign = ~ds; in_divisor_sign = ~bs;
    end else begin
      in_valid = 1'b0;
    end
    cyc = 1;
    while (!out_valid && cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (poke_busy && cyc == 6) in_valid = 1'b0;
    end
    in_valid = 1'b0;
    chk(out_overflow == ovf_exp, "R2 overflow flag", out_overflow, ovf_exp);
    if (ovf_exp) begin
      chk(cyc == 2, "R6 overflow latency", cyc, 2);
    end else begin
      chk(cyc == 2*N + 3 + zero_bits(q_exp), "R7 latency", cyc, 2*N + 3 + zero_bits(q_exp));
      chk(out_quotient == q_exp, "R3 quotient", out_quotient, q_exp);
      chk(out_remainder == r_exp, "R3 remainder", out_remainder, r_exp);
      chk(longint'(out_quotient) * dvs + out_remainder == dvd, "R3 identity",
          longint'(out_quotient) * dvs + out_remainder, dvd);
      chk(out_remainder < dvs, "R3 remainder bound", out_remainder, dvs);
    end
    chk(out_quotient_sign == (ds ^ bs), "R4 quotient sign", out_quotient_sign, ds ^ bs);
    chk(out_remainder_sign == ds, "R5 remainder sign", out_remainder_sign, ds);
    if (stall > 0) begin
      logic [N-1:0] hq, hr;
      hq = out_quotient; hr = out_remainder;
      repeat (stall) @(negedge clk);
      chk(out_valid && out_quotient == hq && out_remainder == hr, "R8 held under stall",
          out_quotient, hq);
      out_ready = 1'b1;
    end
    @(negedge clk);
    chk(in_ready && !out_valid, "R8 idle after transfer", in_ready, 1);
    if (poke_busy) begin
      repeat (4) @(negedge clk);
      chk(!out_valid, "R9 no second result", out_valid, 0);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready at reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1 no result at reset", out_valid, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_basic();      run_div(16'd100, 0, 8'd7, 0, 0, 0); endtask
  task automatic t_signs();
    run_div(16'd1000, 1, 8'd13, 0, 0, 0);
    run_div(16'd1000, 0, 8'd13, 1, 0, 0);
    run_div(16'd777,  1, 8'd9,  1, 0, 0);
  endtask
  task automatic t_overflow();
    run_div(16'h1400, 0, 8'd20, 0, 0, 0);  // high half equals divisor
    run_div(16'h0012, 1, 8'd0,  0, 0, 0);  // zero divisor
    run_div(16'hFFFF, 0, 8'd3,  1, 0, 0);
  endtask
  task automatic t_e_carry();    // R10 shifted-out bit lands in E
    run_div(16'hFEFF, 0, 8'hFF, 0, 0, 0);
    run_div(16'hC123, 0, 8'hC8, 1, 0, 0);
  endtask
  task automatic t_edges();
    run_div(16'd0, 0, 8'd1, 0, 0, 0);
    run_div(16'h00FF, 0, 8'd1, 0, 0, 0);
    run_div(16'h7FFF, 1, 8'h80, 0, 0, 0);
  endtask
  task automatic t_backpressure(); run_div(16'd5000, 1, 8'd77, 0, 5, 0); endtask
  task automatic t_busy_poke();    run_div(16'd4321, 0, 8'd99, 1, 0, 1); endtask

  initial begin
    t_reset();
    t_basic();
    t_signs();
    t_overflow();
    t_e_carry();
    t_edges();
    t_backpressure();
    t_busy_poke();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule